// File: doc/BRIEF.md
# Thread-Partitioned In-Order Issue Queue

This block holds dispatched instructions for a core running many hardware threads in in-order issue mode. The entry array is cut into equal fixed slices, one per thread. Each slice works as a circular FIFO: a dispatched instruction lands at its thread's write pointer, and only the entry at the thread's read pointer can be picked. As a result every thread issues strictly in program order. No age search across the whole array is needed.

Every entry snoops the result-tag broadcast bus and marks a source operand ready when a broadcast tag equals the operand's tag. A head entry is eligible once all of its sources are ready. Each cycle a round-robin selector grants up to the issue width of eligible heads. It starts its search at the thread after the last one granted. Each thread has its own full flag, which holds back dispatch for that thread only, and its own empty flag. A per-thread flush discards a thread's whole slice in one cycle.

Top module: `thread_iq`

## Requirements
- R1: After reset every thread reports empty, no thread reports full, and no issue slot is valid.
- R2: A dispatch stores its instruction in the slice chosen by its thread ID. A slice holds 4 entries. Full rises once 4 entries are held, and a dispatch to a full thread is dropped. Empty is high exactly when the slice holds nothing.
- R3: A full thread holds back only its own dispatches; a dispatch to any other thread is still accepted.
- R4: Within a thread, instructions issue in dispatch order. A head that is not ready blocks the younger entries of its thread, even when those entries are ready.
- R5: A source is marked ready when a valid broadcast carries its tag. A head issues only when all of its sources are ready, and it is shown on the issue port in the cycle after the waking broadcast.
- R6: A broadcast in the same cycle as a dispatch marks the matching source ready as the entry is written, so that entry issues in the next cycle.
- R7: At most 2 instructions issue per cycle, each from a different thread, and at most one from any thread. Slot 0 carries the granted thread nearest the round-robin start, and slot 1 the next one.
- R8: The round-robin search starts at thread 0 after reset. After any issue it starts at the thread following the last thread granted, wrapping from 7 to 0.
- R9: Flushing a thread empties its slice by the next cycle and leaves other threads untouched. A dispatch to that thread in the same cycle is dropped, and the flushed thread issues nothing in that cycle.
- R10: A source flagged ready at dispatch needs no broadcast: a dispatch with all sources ready issues in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request this cycle |
| disp_tid | input | 3 | Thread ID of the dispatch |
| disp_payload | input | 16 | Instruction payload carried to issue |
| disp_src_tag | input | 12 | Two 6-bit source tags, source 0 in the low bits |
| disp_src_rdy | input | 2 | Source already ready at dispatch, bit per source |
| thr_full | output | 8 | Per-thread full flag, bit per thread |
| thr_empty | output | 8 | Per-thread empty flag, bit per thread |
| wb_valid | input | 2 | Valid bit per broadcast lane |
| wb_tag | input | 12 | Two 6-bit broadcast result tags, lane 0 in the low bits |
| flush | input | 8 | Per-thread flush, bit per thread |
| iss_valid | output | 2 | Issue slot valid, bit per slot |
| iss_tid | output | 6 | Thread ID per slot, 3 bits each, slot 0 low |
| iss_payload | output | 32 | Payload per slot, 16 bits each, slot 0 low |

## Verification
Dispatch, wakeup and flush are taken at a clock edge. The issue port is driven combinationally from the stored state, so a dispatch with ready sources, or a waking broadcast, shows on the issue port one cycle after the edge that took it. The shown instruction leaves at the next edge. Flags update one edge after the dispatch or flush that changes them. The bench drives inputs shortly after each rising edge and records issue slots at the falling edge together with a cycle count. Each check compares the recorded cycle with the drive cycle plus one, plus one for each earlier grant from the same thread or for each earlier pair of grants.

// File: rtl/thread_iq_pkg.sv
package thread_iq_pkg;

  // Step a thread index forward around a ring of n threads.
  function automatic int ring_step(input int idx, input int off, input int n);
    return (idx + off) % n;
  endfunction

  // Advance a circular pointer within a partition of the given depth.
  function automatic int ptr_next(input int ptr, input int depth);
    return (ptr == depth - 1) ? 0 : ptr + 1;
  endfunction

endpackage

// File: rtl/thread_iq_slice.sv
module thread_iq_slice #(
  parameter int DEPTH   = 4,
  parameter int NUM_SRC = 2,
  parameter int TAG_W   = 6,
  parameter int WB_W    = 2,
  parameter int PAY_W   = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push,
  input  logic [PAY_W-1:0]         push_payload,
  input  logic [NUM_SRC*TAG_W-1:0] push_tags,
  input  logic [NUM_SRC-1:0]       push_rdy,
  input  logic                     pop,
  input  logic                     flush,
  input  logic [WB_W-1:0]          wb_valid,
  input  logic [WB_W*TAG_W-1:0]    wb_tag,
  output logic                     full,
  output logic                     empty,
  output logic                     head_ready,
  output logic [PAY_W-1:0]         head_payload
);
  import thread_iq_pkg::*;

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DEPTH-1:0]                    ent_vld;
  logic [DEPTH-1:0][NUM_SRC-1:0]       ent_rdy;
  logic [DEPTH-1:0][NUM_SRC*TAG_W-1:0] ent_tags;
  logic [DEPTH-1:0][PAY_W-1:0]         ent_pay;
  logic [PTR_W-1:0]                    head_q, tail_q;
  logic [CNT_W-1:0]                    cnt_q;

  // Named wakeup events: stored entries and the entry being written.
  logic [DEPTH-1:0][NUM_SRC-1:0] wake_hit;
  logic [NUM_SRC-1:0]            push_hit;

  always_comb begin
    wake_hit = '0;
    push_hit = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      for (int w = 0; w < WB_W; w++) begin
        if (wb_valid[w] && push_tags[s*TAG_W +: TAG_W] == wb_tag[w*TAG_W +: TAG_W])
          push_hit[s] = 1'b1;
        for (int e = 0; e < DEPTH; e++) begin
          if (wb_valid[w] && ent_vld[e] &&
              ent_tags[e][s*TAG_W +: TAG_W] == wb_tag[w*TAG_W +: TAG_W])
            wake_hit[e][s] = 1'b1;
        end
      end
    end
  end

  assign full         = (cnt_q == CNT_W'(DEPTH));
  assign empty        = (cnt_q == '0);
  assign head_ready   = ent_vld[head_q] && (&ent_rdy[head_q]);
  assign head_payload = ent_pay[head_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_vld  <= '0;
      ent_rdy  <= '0;
      ent_tags <= '0;
      ent_pay  <= '0;
      head_q   <= '0;
      tail_q   <= '0;
      cnt_q    <= '0;
    end else if (flush) begin
      ent_vld <= '0;
      head_q  <= '0;
      tail_q  <= '0;
      cnt_q   <= '0;
    end else begin
      for (int e = 0; e < DEPTH; e++)
        ent_rdy[e] <= ent_rdy[e] | wake_hit[e];
      if (pop) begin
        ent_vld[head_q] <= 1'b0;
        head_q          <= PTR_W'(ptr_next(int'(head_q), DEPTH));
      end
      if (push) begin
        ent_vld[tail_q]  <= 1'b1;
        ent_pay[tail_q]  <= push_payload;
        ent_tags[tail_q] <= push_tags;
        ent_rdy[tail_q]  <= push_rdy | push_hit;
        tail_q           <= PTR_W'(ptr_next(int'(tail_q), DEPTH));
      end
      cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
    end
  end

  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
  a_r3_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  a_r4_pop_needs_ready_head: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> head_ready);
  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);

endmodule

// File: rtl/thread_iq_select.sv
module thread_iq_select #(
  parameter int NUM_THREADS = 8,
  parameter int ISSUE_W     = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_THREADS-1:0]        cand,
  output logic [NUM_THREADS-1:0]        grant,
  output logic [ISSUE_W-1:0]            slot_vld,
  output logic [ISSUE_W*$clog2(NUM_THREADS)-1:0] slot_tid
);
  import thread_iq_pkg::*;

  localparam int TID_W = $clog2(NUM_THREADS);

  logic [TID_W-1:0] rr_q;
  logic [TID_W-1:0] last_tid;
  logic             any_grant;

  always_comb begin
    int taken;
    int idx;
    taken     = 0;
    grant     = '0;
    slot_vld  = '0;
    slot_tid  = '0;
    last_tid  = rr_q;
    any_grant = 1'b0;
    for (int off = 0; off < NUM_THREADS; off++) begin
      idx = ring_step(int'(rr_q), off, NUM_THREADS);
      if (cand[idx] && taken < ISSUE_W) begin
        grant[idx]                      = 1'b1;
        slot_vld[taken]                 = 1'b1;
        slot_tid[taken*TID_W +: TID_W]  = TID_W'(idx);
        last_tid                        = TID_W'(idx);
        any_grant                       = 1'b1;
        taken                           = taken + 1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      rr_q <= '0;
    else if (any_grant)
      rr_q <= TID_W'(ring_step(int'(last_tid), 1, NUM_THREADS));
  end

  a_r7_grant_width: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grant) <= ISSUE_W);
  a_r7_grant_from_candidates: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~cand) == '0);
  a_r8_pointer_holds_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cand == '0) |=> $stable(rr_q));

endmodule

// File: rtl/thread_iq.sv
module thread_iq #(
  parameter int NUM_THREADS = 8,
  parameter int DEPTH       = 4,
  parameter int ISSUE_W     = 2,
  parameter int NUM_SRC     = 2,
  parameter int TAG_W       = 6,
  parameter int WB_W        = 2,
  parameter int PAY_W       = 16,
  localparam int TID_W      = $clog2(NUM_THREADS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     disp_valid,
  input  logic [TID_W-1:0]         disp_tid,
  input  logic [PAY_W-1:0]         disp_payload,
  input  logic [NUM_SRC*TAG_W-1:0] disp_src_tag,
  input  logic [NUM_SRC-1:0]       disp_src_rdy,
  output logic [NUM_THREADS-1:0]   thr_full,
  output logic [NUM_THREADS-1:0]   thr_empty,
  input  logic [WB_W-1:0]          wb_valid,
  input  logic [WB_W*TAG_W-1:0]    wb_tag,
  input  logic [NUM_THREADS-1:0]   flush,
  output logic [ISSUE_W-1:0]       iss_valid,
  output logic [ISSUE_W*TID_W-1:0] iss_tid,
  output logic [ISSUE_W*PAY_W-1:0] iss_payload
);

  logic [NUM_THREADS-1:0]            push_t;
  logic [NUM_THREADS-1:0]            head_rdy;
  logic [NUM_THREADS-1:0]            cand;
  logic [NUM_THREADS-1:0]            grant;
  logic [NUM_THREADS-1:0][PAY_W-1:0] head_pay;

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_slice
    assign push_t[t] = disp_valid && (disp_tid == TID_W'(t)) && !thr_full[t] && !flush[t];
    assign cand[t]   = head_rdy[t] && !flush[t];

    thread_iq_slice #(
      .DEPTH(DEPTH), .NUM_SRC(NUM_SRC), .TAG_W(TAG_W), .WB_W(WB_W), .PAY_W(PAY_W)
    ) i_slice (
      .clk          (clk),
      .rst_n        (rst_n),
      .push         (push_t[t]),
      .push_payload (disp_payload),
      .push_tags    (disp_src_tag),
      .push_rdy     (disp_src_rdy),
      .pop          (grant[t]),
      .flush        (flush[t]),
      .wb_valid     (wb_valid),
      .wb_tag       (wb_tag),
      .full         (thr_full[t]),
      .empty        (thr_empty[t]),
      .head_ready   (head_rdy[t]),
      .head_payload (head_pay[t])
    );
  end

  thread_iq_select #(
    .NUM_THREADS(NUM_THREADS), .ISSUE_W(ISSUE_W)
  ) i_select (
    .clk      (clk),
    .rst_n    (rst_n),
    .cand     (cand),
    .grant    (grant),
    .slot_vld (iss_valid),
    .slot_tid (iss_tid)
  );

  for (genvar k = 0; k < ISSUE_W; k++) begin : g_slot
    assign iss_payload[k*PAY_W +: PAY_W] = head_pay[iss_tid[k*TID_W +: TID_W]];
  end

  for (genvar i = 0; i < ISSUE_W; i++) begin : g_pair_i
    for (genvar j = i + 1; j < ISSUE_W; j++) begin : g_pair_j
      a_r7_distinct_threads: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid[i] && iss_valid[j]) |->
          (iss_tid[i*TID_W +: TID_W] != iss_tid[j*TID_W +: TID_W]));
    end
  end

  a_r9_flushed_thread_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & flush) == '0);
  a_r1_slots_packed: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_valid[0] |-> (iss_valid == '0));

endmodule

// File: tb/test_thread_iq.sv
module test_thread_iq;
  localparam int NT = 8;
  localparam int TW = 3;
  localparam int PW = 16;
  localparam int GW = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          disp_valid;
  logic [TW-1:0] disp_tid;
  logic [PW-1:0] disp_payload;
  logic [2*GW-1:0] disp_src_tag;
  logic [1:0]    disp_src_rdy;
  logic [NT-1:0] thr_full, thr_empty;
  logic [1:0]    wb_valid;
  logic [2*GW-1:0] wb_tag;
  logic [NT-1:0] flush;
  logic [1:0]    iss_valid;
  logic [2*TW-1:0] iss_tid;
  logic [2*PW-1:0] iss_payload;

  thread_iq i_thread_iq (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_tid(disp_tid),
    .disp_payload(disp_payload), .disp_src_tag(disp_src_tag), .disp_src_rdy(disp_src_rdy),
    .thr_full(thr_full), .thr_empty(thr_empty), .wb_valid(wb_valid), .wb_tag(wb_tag),
    .flush(flush), .iss_valid(iss_valid), .iss_tid(iss_tid), .iss_payload(iss_payload)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int n_log  = 0;
  int log_tid [256];
  int log_pay [256];
  int log_cyc [256];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    for (int k = 0; k < 2; k++) begin
      if (iss_valid[k] && n_log < 256) begin
        log_tid[n_log] = int'(iss_tid[k*TW +: TW]);
        log_pay[n_log] = int'(iss_payload[k*PW +: PW]);
        log_cyc[n_log] = cyc;
        n_log = n_log + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clr();
    disp_valid = 0; disp_tid = '0; disp_payload = '0; disp_src_tag = '0;
    disp_src_rdy = '0; wb_valid = '0; wb_tag = '0; flush = '0;
  endtask

  task automatic tick();
    @(posedge clk); #2; clr();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic do_reset();
    clr(); rst_n = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    n_log = 0;
  endtask

  task automatic put_disp(input int tid, input int pay, input int t0, input int t1, input int rdy);
    disp_valid = 1; disp_tid = TW'(tid); disp_payload = PW'(pay);
    disp_src_tag = {GW'(t1), GW'(t0)}; disp_src_rdy = 2'(rdy);
  endtask

  task automatic put_wb(input int tag);
    wb_valid = 2'b01; wb_tag = {GW'(0), GW'(tag)};
  endtask

  task automatic expect_log(input int i, input int tid, input int c, input string req);
    chk(n_log > i, req, "issue count", n_log, i + 1);
    if (n_log > i) begin
      chk(log_tid[i] == tid, req, "issued thread", log_tid[i], tid);
      chk(log_cyc[i] == c, req, "issue cycle", log_cyc[i], c);
    end
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    chk(thr_empty == '1, "R1", "empty after reset", int'(thr_empty), 255);
    chk(thr_full == '0, "R1", "full after reset", int'(thr_full), 0);
    chk(iss_valid == '0, "R1", "issue after reset", int'(iss_valid), 0);
  endtask

  task automatic t_fill_and_backpressure();
    int c0;
    do_reset();
    for (int s = 0; s < 4; s++) begin
      put_disp(3, 3*16 + s, 11, 11, 0); tick();
    end
    chk(thr_full[3] == 1, "R2", "thread 3 full", int'(thr_full[3]), 1);
    chk(thr_empty[3] == 0, "R2", "thread 3 not empty", int'(thr_empty[3]), 0);
    chk(thr_full[4] == 0, "R3", "thread 4 not full", int'(thr_full[4]), 0);
    put_disp(3, 3*16 + 4, 11, 11, 0); tick();
    put_disp(4, 4*16, 12, 12, 3); c0 = cyc; tick(); idle(2);
    expect_log(0, 4, c0 + 1, "R10");
    chk(n_log == 1 && log_pay[0] == 4*16, "R3", "thread 4 accepted while 3 full", n_log, 1);
    n_log = 0;
    put_wb(11); c0 = cyc; tick(); idle(6);
    chk(n_log == 4, "R2", "fifth dispatch dropped", n_log, 4);
    for (int s = 0; s < 4; s++) begin
      expect_log(s, 3, c0 + 1 + s, "R4");
      if (n_log > s) chk(log_pay[s] == 3*16 + s, "R4", "program order", log_pay[s], 3*16 + s);
    end
    chk(thr_empty[3] == 1, "R2", "thread 3 empty after drain", int'(thr_empty[3]), 1);
  endtask

  task automatic t_head_blocks();
    int c0;
    do_reset();
    put_disp(1, 16'h10, 20, 21, 0); tick();
    put_disp(1, 16'h11, 22, 22, 3); tick();
    idle(3);
    chk(n_log == 0, "R4", "unready head blocks ready younger", n_log, 0);
    put_wb(20); tick(); idle(2);
    chk(n_log == 0, "R5", "one of two sources ready", n_log, 0);
    put_wb(21); c0 = cyc; tick(); idle(3);
    expect_log(0, 1, c0 + 1, "R5");
    expect_log(1, 1, c0 + 2, "R4");
    if (n_log >= 2)
      chk(log_pay[0] == 16'h10 && log_pay[1] == 16'h11, "R4", "order of thread 1", log_pay[0], 16'h10);
  endtask

  task automatic t_same_cycle_wake();
    int c0;
    do_reset();
    put_disp(2, 16'h20, 25, 25, 0); put_wb(25); c0 = cyc; tick(); idle(2);
    chk(n_log == 1, "R6", "same-cycle wakeup kept", n_log, 1);
    expect_log(0, 2, c0 + 1, "R6");
  endtask

  task automatic t_round_robin();
    int c0;
    do_reset();
    for (int t = 0; t < NT; t++) begin
      put_disp(t, t*16, 30, 30, 0); tick();
    end
    put_wb(30); c0 = cyc; tick(); idle(5);
    chk(n_log == 8, "R7", "all eight issued", n_log, 8);
    for (int t = 0; t < NT; t++) expect_log(t, t, c0 + 1 + t/2, "R7");
    n_log = 0;
    put_disp(1, 16, 31, 31, 0); tick();
    put_disp(5, 80, 31, 31, 0); tick();
    put_disp(6, 96, 31, 31, 0); tick();
    put_wb(31); c0 = cyc; tick(); idle(4);
    expect_log(0, 1, c0 + 1, "R8");
    expect_log(1, 5, c0 + 1, "R8");
    expect_log(2, 6, c0 + 2, "R8");
    n_log = 0;
    put_disp(6, 96, 32, 32, 0); tick();
    put_disp(0, 0, 32, 32, 0); tick();
    put_wb(32); c0 = cyc; tick(); idle(3);
    expect_log(0, 0, c0 + 1, "R8");
    expect_log(1, 6, c0 + 1, "R8");
  endtask

  task automatic t_flush();
    do_reset();
    put_disp(3, 16'h30, 40, 40, 0); tick();
    put_disp(4, 16'h40, 40, 40, 0); tick();
    put_disp(3, 16'h3F, 41, 41, 3); flush = 8'h08; tick();
    chk(thr_empty[3] == 1, "R9", "flushed thread empty", int'(thr_empty[3]), 1);
    chk(thr_empty[4] == 0, "R9", "other thread kept", int'(thr_empty[4]), 0);
    idle(2);
    chk(n_log == 0, "R9", "dispatch during flush dropped", n_log, 0);
    put_wb(40); tick(); idle(3);
    chk(n_log == 1, "R9", "only unflushed thread issues", n_log, 1);
    if (n_log > 0) chk(log_tid[0] == 4, "R9", "surviving thread", log_tid[0], 4);
  endtask

  bit done = 0;

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    clr(); rst_n = 0;
    t_reset();
    t_fill_and_backpressure();
    t_head_blocks();
    t_same_cycle_wake();
    t_round_robin();
    t_flush();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule